// File: doc/BRIEF.md
# Context-Switched Two-Level Address Translator

This block turns a virtual address into a physical address in a single lookup. A small context register picks one of several address spaces. The upper bits of the virtual address index a per-context segment table. Each segment slot names one group of page descriptors, and the groups are shared by all contexts. The page-in-segment bits then pick one descriptor inside that group. That descriptor supplies the physical page number, the target type and the access rights. The rights depend on whether the access is a write and whether it comes from supervisor or user mode.

A request is presented for one cycle. The registered response follows on the next cycle. It carries either the physical address with its type and cacheability, or a fault with a cause code. When an access is allowed, the descriptor is marked as referenced, and also as dirty if the access was a write. When an access is refused, the descriptor is left untouched.

A maintenance port writes and reads the context register, the segment table and the descriptor array. Its read data is returned one cycle later.

Top module: `mmu_xlate`

## Requirements
- R1: A maintenance write with select 0 loads the context register from the low CTX_W bits of the write data, and the upper bits are discarded. A maintenance read with select 0 returns the context zero-extended.
- R2: The virtual address splits into segment (top SEG_W bits), page-in-segment (next PIS_W bits) and offset (low OFF_W bits). The segment table is indexed by {context, segment}, and its entry G selects descriptor {G, page-in-segment}. For a permitted access, rsp_paddr = {descriptor[18:0], offset}.
- R3: Descriptor layout: bit 31 valid, bits 30:29 rights, bits 28:26 type, bit 25 referenced, bit 24 dirty, bits 18:0 page number. Only the bits under mask 0xFF07FFFF are stored, so bits 23:19 read back as zero. Maintenance select 1 addresses the segment table at index mnt_addr = {context, segment}. Select 2 addresses the descriptor array at index mnt_addr = {group, page}.
- R4: rsp_valid is high in the cycle after req_valid, and low otherwise.
- R5: A lookup whose descriptor has bit 31 clear faults with rsp_cause = 1.
- R6: Rights encoding: 0 read-only for all, 1 read-only and supervisor only, 2 read/write for all, 3 read/write and supervisor only. A user access to rights 1 or 3 faults with rsp_cause = 2, and so does a write to rights 0 or 1. An allowed access has rsp_cause = 0 and rsp_fault = 0.
- R7: On a fault, rsp_paddr, rsp_type and rsp_cacheable are all zero.
- R8: rsp_type returns descriptor type (0 memory, 1 on-board I/O, 2 narrow external bus, 3 wide external bus, 4 uncached memory). rsp_cacheable is high only for type 0 on a permitted access.
- R9: A permitted read sets bit 25 of the descriptor. A permitted write sets bits 25 and 24. The change is visible to any lookup or maintenance read from the next cycle on.
- R10: A refused access leaves bits 25 and 24 of the descriptor unchanged.
- R11: When a maintenance write and a lookup happen in the same cycle, the lookup uses the contents held before that cycle. If the maintenance write hits the descriptor being marked, the maintenance data wins.
- R12: After reset the context is 0 and all table and descriptor entries are zero, so any lookup faults with cause 1.
- R13: A maintenance read (mnt_valid high, mnt_write low) gives mnt_rvalid and mnt_rdata on the next cycle. Select 3 reads zero. With no read, mnt_rvalid and mnt_rdata are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | VA_W | Virtual address |
| req_write | input | 1 | 1 = write access |
| req_super | input | 1 | 1 = supervisor mode |
| mnt_valid | input | 1 | Maintenance access strobe |
| mnt_write | input | 1 | 1 = maintenance write |
| mnt_sel | input | 2 | 0 context, 1 segment table, 2 descriptors |
| mnt_addr | input | MA_W | Maintenance index |
| mnt_wdata | input | 32 | Maintenance write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | PA_W | Physical address |
| rsp_type | output | 3 | Target type |
| rsp_cacheable | output | 1 | Cacheable flag |
| rsp_fault | output | 1 | Lookup refused |
| rsp_cause | output | 2 | 0 none, 1 invalid, 2 protection |
| mnt_rvalid | output | 1 | Maintenance read data strobe |
| mnt_rdata | output | 32 | Maintenance read data |

## Verification
The bench sweeps every rights code against all four combinations of read/write and user/supervisor. It then reads back each descriptor to confirm that refused accesses left the referenced and dirty bits alone. A design that marked before checking would show stray bits in that readback. A wrong rights decode would grant or refuse the wrong combination.

Same-cycle collisions are driven on purpose. In one case the context is rewritten during a lookup. In another a descriptor is rewritten while the lookup is marking it. A design with the wrong ordering would translate through the new context, or would let the referenced bit overwrite the maintenance data.

Back-to-back lookup and readback check that marks land exactly one cycle later. Invalid descriptors with every other bit set confirm that no stray type, address or cacheable flag leaks out on a fault.

// File: rtl/mmu_xlate_pkg.sv
package mmu_xlate_pkg;
   // descriptor layout (fixed by the software view)
   localparam int PTE_W        = 32;
   localparam int PPN_W        = 19;
   localparam int TYPE_W       = 3;
   localparam int BIT_VALID    = 31;
   localparam int BIT_RIGHT_WR = 30;
   localparam int BIT_RIGHT_SV = 29;
   localparam int TYPE_LSB     = 26;
   localparam int BIT_REF      = 25;
   localparam int BIT_DIRTY    = 24;
   localparam logic [PTE_W-1:0] PTE_KEEP = 32'hFF07_FFFF;
   localparam logic [TYPE_W-1:0] TYPE_CACHED_MEM = 3'd0;

   // maintenance selects
   localparam logic [1:0] SEL_CTX  = 2'd0;
   localparam logic [1:0] SEL_SEG  = 2'd1;
   localparam logic [1:0] SEL_DESC = 2'd2;

   typedef enum logic [1:0] {
      CAUSE_NONE    = 2'd0,
      CAUSE_INVALID = 2'd1,
      CAUSE_PROT    = 2'd2
   } cause_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/mmu_ctx_segmap.sv
module mmu_ctx_segmap
   import mmu_xlate_pkg::*;
#(
   parameter int CTX_W          = 3,
   parameter int SEG_W          = 6,
   parameter int GRP_W          = 5,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int IDX_W         = CTX_W + SEG_W,
   localparam int N_SLOT        = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEG_W-1:0] lk_seg,
   output logic [GRP_W-1:0] lk_grp,
   output logic [CTX_W-1:0] cur_ctx,
   input  logic             ctx_we,
   input  logic [CTX_W-1:0] ctx_wdata,
   input  logic             seg_we,
   input  logic [IDX_W-1:0] seg_widx,
   input  logic [GRP_W-1:0] seg_wdata,
   input  logic [IDX_W-1:0] seg_ridx,
   output logic [GRP_W-1:0] seg_rdata
);
   logic [CTX_W-1:0] ctx_q;
   logic [GRP_W-1:0] slot_q [N_SLOT];

   always_ff @(posedge clk) begin
      if (!rst_n)      ctx_q <= '0;
      else if (ctx_we) ctx_q <= ctx_wdata;
   end

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < N_SLOT; i++) slot_q[i] <= '0;
            end else if (seg_we) begin
               slot_q[seg_widx] <= seg_wdata;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (seg_we) slot_q[seg_widx] <= seg_wdata;
         end
      end
   endgenerate

   assign cur_ctx   = ctx_q;
   assign lk_grp    = slot_q[{ctx_q, lk_seg}];
   assign seg_rdata = slot_q[seg_ridx];
endmodule

// File: rtl/mmu_desc_array.sv
module mmu_desc_array
   import mmu_xlate_pkg::*;
#(
   parameter int GRP_W          = 5,
   parameter int PIS_W          = 4,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int IDX_W         = GRP_W + PIS_W,
   localparam int N_DESC        = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] lk_idx,
   output logic [PTE_W-1:0] lk_word,
   input  logic             mark_we,
   input  logic [IDX_W-1:0] mark_idx,
   input  logic [PTE_W-1:0] mark_word,
   input  logic             mnt_we,
   input  logic [IDX_W-1:0] mnt_idx,
   input  logic [PTE_W-1:0] mnt_word,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [PTE_W-1:0] rd_word
);
   logic [PTE_W-1:0] desc_q [N_DESC];

   // the maintenance write is issued last so it wins a same-index collision
   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < N_DESC; i++) desc_q[i] <= '0;
            end else begin
               if (mark_we) desc_q[mark_idx] <= mark_word & PTE_KEEP;
               if (mnt_we)  desc_q[mnt_idx]  <= mnt_word & PTE_KEEP;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (mark_we) desc_q[mark_idx] <= mark_word & PTE_KEEP;
            if (mnt_we)  desc_q[mnt_idx]  <= mnt_word & PTE_KEEP;
         end
      end
   endgenerate

   assign lk_word = desc_q[lk_idx];
   assign rd_word = desc_q[rd_idx];
endmodule

// File: rtl/mmu_access_check.sv
module mmu_access_check
   import mmu_xlate_pkg::*;
(
   input  logic [PTE_W-1:0] desc,
   input  logic             is_write,
   input  logic             is_super,
   output cause_e           cause,
   output logic             permit,
   output logic [PTE_W-1:0] mark_bits
);
   always_comb begin
      cause = CAUSE_NONE;
      if (!desc[BIT_VALID])
         cause = CAUSE_INVALID;
      else if ((!is_super && desc[BIT_RIGHT_SV]) || (is_write && !desc[BIT_RIGHT_WR]))
         cause = CAUSE_PROT;
      permit    = (cause == CAUSE_NONE);
      mark_bits = '0;
      if (permit) begin
         mark_bits[BIT_REF]   = 1'b1;
         mark_bits[BIT_DIRTY] = is_write;
      end
   end
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
   import mmu_xlate_pkg::*;
#(
   parameter int CTX_W          = 3,
   parameter int SEG_W          = 6,
   parameter int PIS_W          = 4,
   parameter int OFF_W          = 13,
   parameter int GRP_W          = 5,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int VA_W          = SEG_W + PIS_W + OFF_W,
   localparam int PA_W          = PPN_W + OFF_W,
   localparam int MA_W          = max2(CTX_W + SEG_W, GRP_W + PIS_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [VA_W-1:0]   req_va,
   input  logic              req_write,
   input  logic              req_super,
   input  logic              mnt_valid,
   input  logic              mnt_write,
   input  logic [1:0]        mnt_sel,
   input  logic [MA_W-1:0]   mnt_addr,
   input  logic [PTE_W-1:0]  mnt_wdata,
   output logic              rsp_valid,
   output logic [PA_W-1:0]   rsp_paddr,
   output logic [TYPE_W-1:0] rsp_type,
   output logic              rsp_cacheable,
   output logic              rsp_fault,
   output logic [1:0]        rsp_cause,
   output logic              mnt_rvalid,
   output logic [PTE_W-1:0]  mnt_rdata
);
   localparam int SIDX_W = CTX_W + SEG_W;
   localparam int DIDX_W = GRP_W + PIS_W;

   generate
      if (CTX_W < 1 || CTX_W > 8) begin : g_bad_ctx
         $error("CTX_W must lie in 1..8");
      end
      if (GRP_W < 1 || GRP_W > 16) begin : g_bad_grp
         $error("GRP_W must lie in 1..16");
      end
      if (SEG_W < 1 || PIS_W < 1 || OFF_W < 1) begin : g_bad_split
         $error("address fields must be at least one bit");
      end
   endgenerate

   // address split
   logic [SEG_W-1:0] va_seg;
   logic [PIS_W-1:0] va_pis;
   logic [OFF_W-1:0] va_off;
   assign va_seg = req_va[VA_W-1 -: SEG_W];
   assign va_pis = req_va[OFF_W +: PIS_W];
   assign va_off = req_va[OFF_W-1:0];

   // maintenance decode
   logic mnt_wr, mnt_rd;
   assign mnt_wr = mnt_valid && mnt_write;
   assign mnt_rd = mnt_valid && !mnt_write;

   logic [GRP_W-1:0] lk_grp, seg_rdata;
   logic [CTX_W-1:0] cur_ctx;

   mmu_ctx_segmap #(
      .CTX_W(CTX_W), .SEG_W(SEG_W), .GRP_W(GRP_W), .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) u_segmap (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_seg    (va_seg),
      .lk_grp    (lk_grp),
      .cur_ctx   (cur_ctx),
      .ctx_we    (mnt_wr && mnt_sel == SEL_CTX),
      .ctx_wdata (mnt_wdata[CTX_W-1:0]),
      .seg_we    (mnt_wr && mnt_sel == SEL_SEG),
      .seg_widx  (mnt_addr[SIDX_W-1:0]),
      .seg_wdata (mnt_wdata[GRP_W-1:0]),
      .seg_ridx  (mnt_addr[SIDX_W-1:0]),
      .seg_rdata (seg_rdata)
   );

   logic [DIDX_W-1:0] lk_didx;
   logic [PTE_W-1:0]  lk_word, rd_word, mark_bits;
   cause_e            lk_cause;
   logic              lk_permit;
   logic              upd_en;
   logic              lk_deny;

   assign lk_didx = {lk_grp, va_pis};

   mmu_access_check u_check (
      .desc      (lk_word),
      .is_write  (req_write),
      .is_super  (req_super),
      .cause     (lk_cause),
      .permit    (lk_permit),
      .mark_bits (mark_bits)
   );

   assign upd_en  = req_valid && lk_permit;
   assign lk_deny = req_valid && !lk_permit;

   mmu_desc_array #(
      .GRP_W(GRP_W), .PIS_W(PIS_W), .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) u_desc (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_idx    (lk_didx),
      .lk_word   (lk_word),
      .mark_we   (upd_en),
      .mark_idx  (lk_didx),
      .mark_word (lk_word | mark_bits),
      .mnt_we    (mnt_wr && mnt_sel == SEL_DESC),
      .mnt_idx   (mnt_addr[DIDX_W-1:0]),
      .mnt_word  (mnt_wdata),
      .rd_idx    (mnt_addr[DIDX_W-1:0]),
      .rd_word   (rd_word)
   );

   // response stage
   logic [TYPE_W-1:0] lk_type;
   assign lk_type = lk_word[TYPE_LSB +: TYPE_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_paddr     <= '0;
         rsp_type      <= '0;
         rsp_cacheable <= 1'b0;
         rsp_fault     <= 1'b0;
         rsp_cause     <= CAUSE_NONE;
      end else begin
         rsp_valid     <= req_valid;
         rsp_paddr     <= '0;
         rsp_type      <= '0;
         rsp_cacheable <= 1'b0;
         rsp_fault     <= lk_deny;
         rsp_cause     <= req_valid ? lk_cause : CAUSE_NONE;
         if (upd_en) begin
            rsp_paddr     <= {lk_word[PPN_W-1:0], va_off};
            rsp_type      <= lk_type;
            rsp_cacheable <= (lk_type == TYPE_CACHED_MEM);
         end
      end
   end

   // maintenance read stage
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mnt_rvalid <= 1'b0;
         mnt_rdata  <= '0;
      end else begin
         mnt_rvalid <= mnt_rd;
         mnt_rdata  <= '0;
         if (mnt_rd) begin
            case (mnt_sel)
               SEL_CTX:  mnt_rdata <= PTE_W'(cur_ctx);
               SEL_SEG:  mnt_rdata <= PTE_W'(seg_rdata);
               SEL_DESC: mnt_rdata <= rd_word;
               default:  mnt_rdata <= '0;
            endcase
         end
      end
   end
endmodule

// File: rtl/mmu_xlate_chk.sv
module mmu_xlate_chk
   import mmu_xlate_pkg::*;
#(
   parameter int CTX_W = 3,
   parameter int PA_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              mnt_valid,
   input logic              mnt_write,
   input logic [1:0]        mnt_sel,
   input logic              rsp_valid,
   input logic [PA_W-1:0]   rsp_paddr,
   input logic [TYPE_W-1:0] rsp_type,
   input logic              rsp_cacheable,
   input logic              rsp_fault,
   input logic [1:0]        rsp_cause,
   input logic              mnt_rvalid,
   input logic [PTE_W-1:0]  mnt_rdata,
   input logic              lk_deny,
   input logic              upd_en
);
   assert_rsp_follows_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   assert_no_spurious_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   assert_fault_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (rsp_cause != 2'd0));
   assert_clean_has_no_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fault) |-> (rsp_cause == 2'd0));
   assert_fault_hides_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (rsp_paddr == '0 && rsp_type == '0 && !rsp_cacheable));
   assert_cacheable_type0_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_cacheable |-> (rsp_type == TYPE_CACHED_MEM && !rsp_fault));
   assert_no_mark_on_deny_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lk_deny |-> !upd_en);
   assert_read_returns_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (mnt_valid && !mnt_write) |=> mnt_rvalid);
   assert_ctx_zero_ext_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mnt_valid && !mnt_write && mnt_sel == SEL_CTX) |=> (mnt_rdata[PTE_W-1:CTX_W] == '0));
   assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mnt_valid && !mnt_write && mnt_sel == SEL_DESC) |=> (mnt_rdata[23:19] == 5'd0));
endmodule

bind mmu_xlate mmu_xlate_chk #(.CTX_W(CTX_W), .PA_W(PA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .mnt_valid     (mnt_valid),
   .mnt_write     (mnt_write),
   .mnt_sel       (mnt_sel),
   .rsp_valid     (rsp_valid),
   .rsp_paddr     (rsp_paddr),
   .rsp_type      (rsp_type),
   .rsp_cacheable (rsp_cacheable),
   .rsp_fault     (rsp_fault),
   .rsp_cause     (rsp_cause),
   .mnt_rvalid    (mnt_rvalid),
   .mnt_rdata     (mnt_rdata),
   .lk_deny       (lk_deny),
   .upd_en        (upd_en)
);

// File: tb/mmu_xlate_tb.sv
module mmu_xlate_tb;
   timeunit 1ns;
   timeprecision 1ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 0, req_write = 0, req_super = 0;
   logic [22:0] req_va = '0;
   logic        mnt_valid = 0, mnt_write = 0;
   logic [1:0]  mnt_sel = '0;
   logic [8:0]  mnt_addr = '0;
   logic [31:0] mnt_wdata = '0;
   logic        rsp_valid, rsp_cacheable, rsp_fault, mnt_rvalid;
   logic [31:0] rsp_paddr, mnt_rdata;
   logic [2:0]  rsp_type;
   logic [1:0]  rsp_cause;

   always #10 clk = ~clk;

   mmu_xlate u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
      .req_write(req_write), .req_super(req_super), .mnt_valid(mnt_valid),
      .mnt_write(mnt_write), .mnt_sel(mnt_sel), .mnt_addr(mnt_addr),
      .mnt_wdata(mnt_wdata), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
      .rsp_type(rsp_type), .rsp_cacheable(rsp_cacheable), .rsp_fault(rsp_fault),
      .rsp_cause(rsp_cause), .mnt_rvalid(mnt_rvalid), .mnt_rdata(mnt_rdata)
   );

   int    checks = 0, errors = 0;
   string phase = "R12 reset";
   bit    comparing = 0;
   bit    done = 0;

   // behavioural reference
   int          m_ctx;
   logic [4:0]  m_seg [512];
   logic [31:0] m_pg  [512];
   logic        e_v, e_ca, e_f, e_rv;
   logic [31:0] e_pa, e_rd;
   logic [2:0]  e_t;
   logic [1:0]  e_c;
   int          sidx, pidx;
   logic [31:0] ent;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctx = 0;
         for (int i = 0; i < 512; i++) begin m_seg[i] = '0; m_pg[i] = '0; end
         e_v = 0; e_ca = 0; e_f = 0; e_rv = 0; e_pa = 0; e_rd = 0; e_t = 0; e_c = 0;
      end else begin
         e_rv = mnt_valid && !mnt_write;
         e_rd = 0;
         if (e_rv) begin
            if (mnt_sel == 0)      e_rd = m_ctx;
            else if (mnt_sel == 1) e_rd = {27'd0, m_seg[mnt_addr]};
            else if (mnt_sel == 2) e_rd = m_pg[mnt_addr];
         end
         e_v = req_valid; e_f = 0; e_c = 0; e_pa = 0; e_t = 0; e_ca = 0;
         if (req_valid) begin
            sidx = m_ctx * 64 + int'(req_va[22:17]);
            pidx = int'(m_seg[sidx]) * 16 + int'(req_va[16:13]);
            ent  = m_pg[pidx];
            if (!ent[31]) e_c = 1;
            else if ((!req_super && ent[29]) || (req_write && !ent[30])) e_c = 2;
            if (e_c == 0) begin
               e_pa = {ent[18:0], req_va[12:0]};
               e_t  = ent[28:26];
               e_ca = (e_t == 0);
               m_pg[pidx] = ent | 32'h0200_0000 | (req_write ? 32'h0100_0000 : 32'h0);
            end else e_f = 1;
         end
         if (mnt_valid && mnt_write) begin
            if (mnt_sel == 0)      m_ctx = int'(mnt_wdata & 32'h7);
            else if (mnt_sel == 1) m_seg[mnt_addr] = mnt_wdata[4:0];
            else if (mnt_sel == 2) m_pg[mnt_addr] = mnt_wdata & 32'hFF07_FFFF;
         end
      end
   end

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s during %s: actual %h expected %h", what, phase, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (comparing && !done) begin
         chk(rsp_valid == e_v, "R4 rsp_valid", 32'(rsp_valid), 32'(e_v));
         chk(rsp_paddr == e_pa, "R2 rsp_paddr", rsp_paddr, e_pa);
         chk(rsp_type == e_t, "R8 rsp_type", 32'(rsp_type), 32'(e_t));
         chk(rsp_cacheable == e_ca, "R8 rsp_cacheable", 32'(rsp_cacheable), 32'(e_ca));
         chk(rsp_fault == e_f, "R5 rsp_fault", 32'(rsp_fault), 32'(e_f));
         chk(rsp_cause == e_c, "R6 rsp_cause", 32'(rsp_cause), 32'(e_c));
         chk(mnt_rvalid == e_rv, "R13 mnt_rvalid", 32'(mnt_rvalid), 32'(e_rv));
         chk(mnt_rdata == e_rd, "R13 mnt_rdata", mnt_rdata, e_rd);
      end
   end

   function automatic logic [22:0] va(input int seg, input int pis, input int off);
      return {6'(seg), 4'(pis), 13'(off)};
   endfunction

   task automatic drive(input bit rv, input logic [22:0] a, input bit wr, input bit sup,
                        input bit mv, input bit mw, input logic [1:0] sel,
                        input logic [8:0] ma, input logic [31:0] d);
      @(negedge clk);
      req_valid = rv; req_va = a; req_write = wr; req_super = sup;
      mnt_valid = mv; mnt_write = mw; mnt_sel = sel; mnt_addr = ma; mnt_wdata = d;
   endtask

   task automatic req(input logic [22:0] a, input bit wr, input bit sup);
      drive(1, a, wr, sup, 0, 0, 0, 0, 0);
   endtask
   task automatic mwr(input logic [1:0] sel, input logic [8:0] ma, input logic [31:0] d);
      drive(0, 0, 0, 0, 1, 1, sel, ma, d);
   endtask
   task automatic mrd(input logic [1:0] sel, input logic [8:0] ma);
      drive(0, 0, 0, 0, 1, 0, sel, ma, 0);
   endtask
   task automatic nop();
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic finish_run();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog during %s: actual hung expected finished", phase);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      comparing = 1;
      // R12: empty maps fault as invalid
      req(va(0, 0, 0), 0, 1);
      req(va(5, 3, 1), 1, 0);
      mrd(2, 0);
      mrd(1, 9);
      mrd(0, 0);
      // R1: context keeps low bits only
      phase = "R1 context";
      mwr(0, 0, 32'h0000_00FD);
      mrd(0, 0);
      // R3: storage mask and maintenance indexing
      phase = "R3 storage";
      mwr(1, {3'd5, 6'd3}, 32'hFFFF_FFE7);
      mwr(2, {5'd7, 4'd2}, 32'hC0F9_234A);
      mrd(2, {5'd7, 4'd2});
      mrd(1, {3'd5, 6'd3});
      mrd(3, 0);
      // R2: basic translation, user read
      phase = "R2 translate";
      req(va(3, 2, 13'h0ABC), 0, 0);
      // R9: marks visible the very next cycle
      phase = "R9 marking";
      mrd(2, {5'd7, 4'd2});
      req(va(3, 2, 13'h1FFF), 1, 0);
      mrd(2, {5'd7, 4'd2});
      // R6 / R10: every rights code against every mode
      phase = "R6 R10 rights sweep";
      for (int p = 0; p < 4; p++) begin
         mwr(2, 9'({5'd7, 4'(4 + p)}), 32'h8000_0000 | (32'(p) << 29) | (32'(p + 1) << 26) | 32'(16'h100 + p));
         for (int w = 0; w < 2; w++) begin
            for (int s = 0; s < 2; s++) begin
               req(va(3, 4 + p, 13'h0040 + w * 2 + s), bit'(w), bit'(s));
               mrd(2, 9'({5'd7, 4'(4 + p)}));
            end
         end
      end
      // R8: all type codes, permitted reads
      phase = "R8 types";
      for (int t = 0; t < 5; t++) begin
         mwr(2, 9'({5'd7, 4'(8 + t)}), 32'hC000_0000 | (32'(t) << 26) | 32'h7_0000 | 32'(t));
         req(va(3, 8 + t, 13'h0123), 0, 0);
      end
      // R5 R7: invalid entry with everything else set
      phase = "R5 R7 invalid";
      mwr(2, {5'd7, 4'd13}, 32'h7FFF_FFFF);
      req(va(3, 13, 13'h1111), 0, 1);
      req(va(3, 13, 13'h0222), 1, 1);
      mrd(2, {5'd7, 4'd13});
      // R11: collisions inside one cycle
      phase = "R11 same-cycle";
      drive(1, va(3, 2, 13'h0777), 1, 1, 1, 1, 2, {5'd7, 4'd2}, 32'hC000_0055);
      mrd(2, {5'd7, 4'd2});
      drive(1, va(3, 2, 13'h0010), 0, 1, 1, 1, 0, 0, 32'h0000_0001);
      req(va(3, 2, 13'h0010), 0, 1);
      drive(1, va(3, 2, 13'h0020), 0, 1, 1, 1, 1, {3'd1, 6'd3}, 32'h0000_0007);
      req(va(3, 2, 13'h0020), 0, 1);
      mrd(0, 0);
      // R9 R2: second context sharing the same group
      phase = "R9 shared group";
      req(va(3, 2, 13'h0030), 1, 1);
      mrd(2, {5'd7, 4'd2});
      nop();
      nop();
      nop();
      finish_run();
   end
endmodule